// File: doc/BRIEF.md
# Mixed-Width Register Bus Adapter

The adapter sits between a processor-side access port and a back end of registers with different native widths. The processor side issues byte, halfword or longword accesses into a 512-byte register window, using big-endian byte order. A table of width codes, one code for each aligned 4-byte group, gives the native width of the registers in that group. The adapter turns every access into the back-end accesses that width calls for:

- An access of the native width passes through unchanged.
- An access wider than the native width is cut into native-sized pieces, most significant piece first.
- A narrow read of a wider register reads the whole register and returns the addressed bytes.
- A narrow write to a wider register reads the register, merges the new bytes in, and writes the register back.

Out-of-window, misaligned and unmapped accesses are answered with an error and never reach the back end.

Both sides use valid/ready handshakes:

- **Request port.** `req_ready` is high only while the adapter is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` for as long as it likes.
- **Back end.** The back end may stall by holding `be_ready` low. While it stalls, `be_valid` and all request fields stay steady. For a read, `be_rdata` must be valid in the cycle in which `be_ready` is high.
- **Response.** The response is a one-cycle pulse on `rsp_valid` and cannot be stalled.

Top module: `regwin_adapter`

## Requirements
- R1: The native width of group g = addr[8:2] is coded 0 unmapped, 1 byte, 2 halfword, 3 longword, and is set by g mod 4: 0 gives longword, 1 halfword, 2 byte, 3 unmapped. Every back-end access has `be_size` = code-1 (0 byte, 1 halfword, 2 longword) and an address aligned to that size.
- R2: An access whose size (`req_size` 0 byte, 1 halfword, 2 longword) equals the native size makes exactly one back-end access at the same address with the same data.
- R3: A read narrower than the native size makes one back-end read at the address rounded down to the native size. It returns the addressed bytes in big-endian order, right-justified in `rsp_rdata`: the lowest address is the most significant byte.
- R4: A write narrower than the native size makes one back-end read and then one back-end write of the whole native register. Only the addressed bytes change.
- R5: An access wider than the native size makes 2 or 4 native accesses at ascending addresses. The first piece carries the most significant part of the data, both for writes and for the assembled read result.
- R6: An access raises `rsp_err` with `rsp_rdata` = 0 and makes no back-end access when any of these holds: the offset is 512 or more, the address is not aligned to the access size, `req_size` is 3, or the group code is 0.
- R7: While `be_valid` is high and `be_ready` is low, `be_valid`, `be_addr`, `be_we` and `be_wdata` hold their values into the next cycle.
- R8: `rsp_valid` pulses for one cycle. A valid response follows its last back-end handshake by one cycle; an error response follows acceptance by one cycle. `req_ready` is low from acceptance until the cycle after the pulse.
- R9: After reset, `req_ready` is 1 and `be_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Adapter idle, request taken |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 10 | Byte offset into the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data, right-justified |
| be_valid | output | 1 | Back-end request present |
| be_ready | input | 1 | Back end takes the request |
| be_we | output | 1 | Back-end write |
| be_addr | output | 9 | Back-end byte address |
| be_size | output | 2 | Native size of the access |
| be_wdata | output | 32 | Back-end write data, right-justified |
| be_rdata | input | 32 | Back-end read data, right-justified |

## Verification
The hardest situation to reach is a back-end stall in the middle of a multi-step access. Examples are the write-back half of a read-modify-write, or the third piece of a longword split into bytes. The bench lowers `be_ready` in a repeating pattern whose period is prime to the step counts, so stalls land on every step position across the sweep. Every offset in the window, plus a few beyond it, is accessed at all sizes in read, write, read order. The back-end model is a byte array that checks each native access against the width rule.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WB, S_RESP} seq_st_t;

  // Width code per 4-byte group: 0 none, 1 byte, 2 half, 3 word
  function automatic logic [1:0] grp_code(input int g);
    case (g % 4)
      0: return 2'd3;
      1: return 2'd2;
      2: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/regwin_width_lut.sv
module regwin_width_lut #(
  parameter int NGRP = 128,
  localparam int GW = $clog2(NGRP)
) (
  input  logic [GW-1:0] grp,
  output logic [1:0]    code
);
  logic [1:0] tbl [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_ent
    assign tbl[g] = regwin_pkg::grp_code(g);
  end
  assign code = tbl[grp];
endmodule

// File: rtl/regwin_lane.sv
module regwin_lane (
  input  logic [1:0]  rsz,
  input  logic [1:0]  nsz,
  input  logic [1:0]  off,
  input  logic [31:0] nat_rd,
  input  logic [31:0] ins,
  output logic [31:0] ext,
  output logic [31:0] mrg
);
  logic       narrow;
  logic [1:0] ex;
  logic [2:0] nb_n, nb_r, offn;
  logic [5:0] sh;
  logic [31:0] mask;

  always_comb begin
    narrow = rsz < nsz;
    ex     = narrow ? rsz : nsz;
    nb_n   = 3'd1 << nsz;
    nb_r   = 3'd1 << rsz;
    offn   = {1'b0, off} & (nb_n - 3'd1);
    sh     = narrow ? {(nb_n - nb_r - offn), 3'b000} : 6'd0;
    mask   = (ex == 2'd2) ? 32'hFFFF_FFFF : ((32'd1 << (6'd8 << ex)) - 32'd1);
    ext    = (nat_rd >> sh) & mask;
    mrg    = (nat_rd & ~(mask << sh)) | ((ins & mask) << sh);
  end
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq #(
  parameter int ADDR_W = 10,
  parameter int WIN    = 512,
  localparam int BAW   = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        nat_code,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              be_valid,
  input  logic              be_ready,
  output logic              be_we,
  output logic [BAW-1:0]    be_addr,
  output logic [1:0]        be_size,
  output logic [31:0]       be_wdata,
  output logic [1:0]        lane_rsz,
  output logic [1:0]        lane_nsz,
  output logic [1:0]        lane_off,
  output logic [31:0]       lane_ins,
  input  logic [31:0]       lane_ext,
  input  logic [31:0]       lane_mrg
);
  import regwin_pkg::*;

  seq_st_t           st;
  logic              we_q, err_q;
  logic [BAW-1:0]    addr_q;
  logic [1:0]        rsz_q, nsz_q, cnt_q, npc_q;
  logic [31:0]       wl_q, acc_q, mbuf_q;

  // request decode
  logic       mis, dec_err;
  logic [1:0] dec_nsz, dec_npc, diff;
  always_comb begin
    case (req_size)
      2'd0:    mis = 1'b0;
      2'd1:    mis = req_addr[0];
      2'd2:    mis = |req_addr[1:0];
      default: mis = 1'b1;
    endcase
    dec_err = (req_addr >= ADDR_W'(WIN)) || mis || (nat_code == 2'd0);
    dec_nsz = nat_code - 2'd1;
    diff    = req_size - dec_nsz;
    dec_npc = (req_size > dec_nsz) ? ((diff == 2'd2) ? 2'd3 : 2'd1) : 2'd0;
  end

  // step datapath
  logic           narrow, hs, last;
  logic [BAW-1:0] nmask;
  always_comb begin
    narrow   = rsz_q < nsz_q;
    hs       = be_valid && be_ready;
    last     = cnt_q == npc_q;
    nmask    = BAW'((3'd1 << nsz_q) - 3'd1);
    be_valid = (st == S_RUN) || (st == S_WB);
    be_we    = (st == S_WB) || ((st == S_RUN) && we_q && !narrow);
    be_size  = nsz_q;
    be_addr  = narrow ? (addr_q & ~nmask) : (addr_q + (BAW'(cnt_q) << nsz_q));
    be_wdata = (st == S_WB) ? mbuf_q : (wl_q >> (6'd32 - (6'd8 << nsz_q)));
    lane_rsz = rsz_q;
    lane_nsz = nsz_q;
    lane_off = addr_q[1:0];
    lane_ins = wl_q >> (6'd32 - (6'd8 << rsz_q));
    req_ready = (st == S_IDLE);
    rsp_valid = (st == S_RESP);
    rsp_err   = (st == S_RESP) && err_q;
    rsp_rdata = (st == S_RESP) ? acc_q : 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; we_q <= 1'b0; err_q <= 1'b0; addr_q <= '0;
      rsz_q <= '0; nsz_q <= '0; cnt_q <= '0; npc_q <= '0;
      wl_q <= '0; acc_q <= '0; mbuf_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          we_q   <= req_we;
          err_q  <= dec_err;
          addr_q <= req_addr[BAW-1:0];
          rsz_q  <= req_size;
          nsz_q  <= dec_nsz;
          npc_q  <= dec_npc;
          cnt_q  <= '0;
          acc_q  <= '0;
          wl_q   <= req_wdata << (6'd32 - (6'd8 << req_size));
          st     <= dec_err ? S_RESP : S_RUN;
        end
        S_RUN: if (hs) begin
          if (narrow && we_q) begin
            mbuf_q <= lane_mrg;
            st     <= S_WB;
          end else begin
            if (!we_q) acc_q <= (acc_q << (6'd8 << (narrow ? rsz_q : nsz_q))) | lane_ext;
            wl_q  <= wl_q << (6'd8 << nsz_q);
            cnt_q <= cnt_q + 2'd1;
            if (last) st <= S_RESP;
          end
        end
        S_WB: if (hs) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: back-end request held steady under stall
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid && !be_ready |=> be_valid && $stable(be_addr) && $stable(be_we) && $stable(be_wdata));
  // R8: completion is a single-cycle pulse
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8: no new request accepted while responding
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R6: error response carries zero data and no back-end traffic preceded it
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'd0 && $past(!be_valid));
  // R2: back-end traffic only happens while a request is in flight
  p_be_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid |-> !req_ready && !rsp_valid);
endmodule

// File: rtl/regwin_adapter.sv
module regwin_adapter #(
  parameter int ADDR_W = 10,
  parameter int WIN    = 512,
  localparam int BAW   = $clog2(WIN),
  localparam int NGRP  = WIN / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              be_valid,
  input  logic              be_ready,
  output logic              be_we,
  output logic [BAW-1:0]    be_addr,
  output logic [1:0]        be_size,
  output logic [31:0]       be_wdata,
  input  logic [31:0]       be_rdata
);
  logic [1:0]  nat_code, l_rsz, l_nsz, l_off;
  logic [31:0] l_ins, l_ext, l_mrg;

  regwin_width_lut #(.NGRP(NGRP)) u_lut (
    .grp(req_addr[BAW-1:2]), .code(nat_code));

  regwin_lane u_lane (
    .rsz(l_rsz), .nsz(l_nsz), .off(l_off), .nat_rd(be_rdata),
    .ins(l_ins), .ext(l_ext), .mrg(l_mrg));

  regwin_seq #(.ADDR_W(ADDR_W), .WIN(WIN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .nat_code(nat_code),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .be_valid(be_valid), .be_ready(be_ready), .be_we(be_we),
    .be_addr(be_addr), .be_size(be_size), .be_wdata(be_wdata),
    .lane_rsz(l_rsz), .lane_nsz(l_nsz), .lane_off(l_off),
    .lane_ins(l_ins), .lane_ext(l_ext), .lane_mrg(l_mrg));

  // R1: back-end size always within the native range
  p_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    be_valid |-> be_size != 2'd3);
endmodule

// File: tb/test_regwin_adapter.sv
module test_regwin_adapter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, be_ready = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0, be_rdata;
  logic req_ready, rsp_valid, rsp_err, be_valid, be_we;
  logic [31:0] rsp_rdata, be_wdata;
  logic [8:0]  be_addr;
  logic [1:0]  be_size;

  int nchk = 0, nfail = 0, hs_cnt = 0, cyc = 0;
  logic [7:0] mem [512];
  logic [7:0] refm [512];
  logic       stalled = 1'b0;
  logic [8:0] st_addr;
  logic [31:0] st_wdata;

  always #5 clk = ~clk;

  regwin_adapter i_regwin_adapter (.*);

  function automatic int code_of(input int a);
    case ((a >> 2) % 4)
      0: return 3;
      1: return 2;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] init_b(input int i);
    return 8'((i * 37) + 11);
  endfunction

  // back-end model: byte array, big-endian
  always_comb begin
    be_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << be_size) && (int'(be_addr) + k) < 512)
        be_rdata = (be_rdata << 8) | 32'(mem[int'(be_addr) + k]);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_b(i);
    end else if (be_valid && be_ready) begin
      hs_cnt <= hs_cnt + 1;
      nchk <= nchk + 1;
      if (int'(be_size) != code_of(int'(be_addr)) - 1 ||
          (int'(be_addr) % (1 << be_size)) != 0) begin
        nfail <= nfail + 1;
        $display("FAIL R1: native access addr=%0h size=%0d, expected size %0d aligned",
                 be_addr, be_size, code_of(int'(be_addr)) - 1);
      end
      if (be_we)
        for (int k = 0; k < 4; k++)
          if (k < (1 << be_size))
            mem[int'(be_addr) + k] <= be_wdata[8*((1 << be_size) - 1 - k) +: 8];
    end
  end

  // stall pattern and R7 hold monitor
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && stalled) begin
      nchk <= nchk + 1;
      if (!be_valid || be_addr != st_addr || be_wdata != st_wdata) begin
        nfail <= nfail + 1;
        $display("FAIL R7: stalled request changed: valid=%0b addr=%0h data=%0h, expected 1 %0h %0h",
                 be_valid, be_addr, be_wdata, st_addr, st_wdata);
      end
    end
    be_ready <= (cyc % 7) != 2 && (cyc % 7) != 5;
    stalled  <= be_valid && !((cyc % 7) != 2 && (cyc % 7) != 5);
    st_addr  <= be_addr;
    st_wdata <= be_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input int a, input int sz, input bit we, input logic [31:0] wd);
    bit err;
    int nat, exp_hs, t, nb;
    logic [31:0] exp_rd;
    err = (a >= 512) || (sz == 3) || ((a % (1 << sz)) != 0) || (code_of(a) == 0);
    nat = code_of(a) - 1;
    nb  = 1 << sz;
    if (err) exp_hs = 0;
    else if (sz >= nat) exp_hs = 1 << (sz - nat);
    else exp_hs = we ? 2 : 1;
    exp_rd = '0;
    if (!err && !we)
      for (int k = 0; k < nb; k++) exp_rd = (exp_rd << 8) | 32'(refm[a + k]);
    @(negedge clk);
    hs_cnt = 0;
    req_valid = 1'b1; req_we = we; req_addr = 10'(a); req_size = 2'(sz); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 60) begin @(negedge clk); t++; end
    check(rsp_valid, "R8 response", 32'(rsp_valid), 32'd1);
    check(rsp_err == err, "R6 error flag", 32'(rsp_err), 32'(err));
    if (!we) check(rsp_rdata == exp_rd,
                   err ? "R6 data" : (sz > nat ? "R5 read" : (sz < nat ? "R3 read" : "R2 read")),
                   rsp_rdata, exp_rd);
    check(hs_cnt == exp_hs,
          err ? "R6 count" : (sz > nat ? "R5 count" : (sz < nat ? "R4 count" : "R2 count")),
          32'(hs_cnt), 32'(exp_hs));
    if (!err && we)
      for (int k = 0; k < nb; k++) refm[a + k] = wd[8*(nb - 1 - k) +: 8];
    if (a < 512)
      for (int k = 0; k < 4; k++)
        check(mem[(a & ~3) + k] == refm[(a & ~3) + k],
              we ? (sz < nat ? "R4 bytes" : "R5 bytes") : "R3 bytes",
              32'(mem[(a & ~3) + k]), 32'(refm[(a & ~3) + k]));
    @(negedge clk);
    check(!rsp_valid && req_ready, "R8 pulse", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 512; i++) refm[i] = init_b(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !be_valid && !rsp_valid, "R9 reset",
          {29'd0, req_ready, be_valid, rsp_valid}, 32'd4);
    for (int a = 0; a < 520; a++)
      for (int sz = 0; sz < 3; sz++) begin
        access(a, sz, 1'b0, '0);
        access(a, sz, 1'b1, 32'hC3A5_0F96 ^ (32'(a) * 32'h0101_0101) ^ 32'(sz * 77));
        access(a, sz, 1'b0, '0);
      end
    access(0, 3, 1'b0, '0);          // R6 illegal size
    access(1023, 0, 1'b1, 32'hFF);   // R6 far out of window
    access(1020, 2, 1'b0, '0);       // R6 far out of window
    finish_up();
  end
endmodule